// File: doc/BRIEF.md
# E2M1 Round-Nearest-Even Pair Converter

This block takes two single-precision values that an upstream stage has already scaled into the 4-bit E2M1 range. It rounds each one to the nearest point of the 4-bit grid and packs the two resulting codes into one byte. Ties go to the neighbour whose mantissa bit is even, and out-of-range or non-finite inputs clamp to the largest finite code.

The 4-bit code has a sign bit, two exponent bits with a bias of 1, and one mantissa bit. Exponent code 00 holds only zero and the subnormal value 0.5. Because of this layout, the low three bits of a code count upward through the magnitudes in order. The converter therefore finds the magnitude index by comparing the input's magnitude bits against the seven midpoints. It does no floating-point arithmetic.

A parameter selects between a purely combinational path and a single output register stage with its own valid flag.

Top module: `e2m1_pair_packer`

## Requirements
- R1: Positive inputs that sit exactly on the grid map to these codes: 0.0→0x0, 0.5→0x1, 1.0→0x2, 1.5→0x3, 2.0→0x4, 3.0→0x5, 4.0→0x6, 6.0→0x7.
- R2: Each code has the sign in bit 3, the exponent field (bias 1) in bits 2:1 and the mantissa bit in bit 0. Exponent code 00 is used only for 0.0 and 0.5. Bits 2:0 never decrease as the input magnitude grows.
- R3: Any magnitude above 5.0, including infinity and NaN, gives magnitude bits 111 (6.0).
- R4: A magnitude strictly between two midpoints rounds to the nearer grid point, for example 0.3→0.5, 2.2→2.0, 2.7→3.0 and 1.3→1.5.
- R5: A magnitude exactly on a midpoint rounds to the neighbour with mantissa bit 0: 0.25→0.0, 0.75→1.0, 1.25→1.0, 1.75→2.0, 2.5→2.0, 3.5→4.0, 5.0→4.0.
- R6: The sign bit of the input is always copied into bit 3 of the code. A negative value that rounds to zero magnitude encodes as 0x8.
- R7: The code for a_i goes in byte bits 7:4 and the code for b_i goes in bits 3:0.
- R8: With REG_OUT=1, valid_o and byte_o follow one clock after a cycle with valid_i high. byte_o holds its value while valid_i is low. Reset clears both to zero. With REG_OUT=0, byte_o follows the inputs in the same cycle.
- R9: Magnitudes below 0.25, including FP32 subnormals, give magnitude bits 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input pair is valid |
| a_i | input | 32 | First FP32 operand (high nibble) |
| b_i | input | 32 | Second FP32 operand (low nibble) |
| valid_o | output | 1 | Output byte is valid |
| byte_o | output | 8 | Packed pair of E2M1 codes |

## Verification
The assertions check four things on every evaluation:
- the sign bit passes through unchanged;
- every magnitude above the top midpoint, or non-finite, saturates;
- every magnitude below the first midpoint goes to zero;
- the midpoint comparisons form a thermometer code.

They also check, on every cycle, the one-cycle valid latency and the holding of the output byte. The exact tie behaviour, the nibble order, the negative-zero encoding and the correct rounding of values between midpoints can only be shown by the bench scenarios. The bench compares those against a real-arithmetic nearest-point model.

// File: rtl/e2m1_pkg.sv
package e2m1_pkg;
  localparam int FP_W    = 32;
  localparam int CODE_W  = 4;
  localparam int NUM_MID = 7;
  localparam int MAG_W   = FP_W - 1;

  typedef logic [CODE_W-1:0] e2m1_t;

  // FP32 magnitude bits of 0.25 0.75 1.25 1.75 2.5 3.5 5.0, ascending
  localparam logic [MAG_W-1:0] MID_MAG [NUM_MID] = '{
    31'h3E80_0000, 31'h3F40_0000, 31'h3FA0_0000, 31'h3FE0_0000,
    31'h4020_0000, 31'h4060_0000, 31'h40A0_0000
  };

  // midpoint j lies between grid index j and j+1; a tie goes up when j+1 is even
  function automatic bit tie_rounds_up(int j);
    return ((j + 1) % 2) == 0;
  endfunction
endpackage

// File: rtl/e2m1_rne_cvt.sv
module e2m1_rne_cvt
  import e2m1_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  output e2m1_t           code_o
);
  logic             sign;
  logic [7:0]       exp_f;
  logic [MAG_W-1:0] mag;
  logic             non_finite;
  logic [NUM_MID-1:0] above;
  logic [2:0]       idx;

  assign sign       = val_i[FP_W-1];
  assign exp_f      = val_i[30:23];
  assign mag        = val_i[MAG_W-1:0];
  assign non_finite = &exp_f;

  // finite FP32 magnitudes order like unsigned integers
  for (genvar j = 0; j < NUM_MID; j++) begin : g_mid
    if (tie_rounds_up(j)) begin : g_up
      assign above[j] = mag >= MID_MAG[j];
    end else begin : g_down
      assign above[j] = mag > MID_MAG[j];
    end
  end

  always_comb begin
    idx = '0;
    for (int j = 0; j < NUM_MID; j++) idx = idx + 3'(above[j]);
  end

  assign code_o = {sign, non_finite ? 3'd7 : idx};

  always_comb begin
    if (!$isunknown(val_i)) begin
      AST_SIGN_KEPT: assert (code_o[3] == val_i[31]); // R6
      AST_THERMO: assert ((above & (above + 1'b1)) == '0); // R2
      if (non_finite || mag > MID_MAG[NUM_MID-1])
        AST_SATURATE: assert (code_o[2:0] == 3'd7); // R3
      if (mag < MID_MAG[0])
        AST_ZERO_BAND: assert (code_o[2:0] == 3'd0); // R9
    end
  end
endmodule

// File: rtl/e2m1_out_stage.sv
module e2m1_out_stage #(
  parameter bit REG_OUT = 1'b1,
  parameter int W       = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        data_q <= '0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) data_q <= data_i;
      end
    end

    assign valid_o = vld_q;
    assign data_o  = data_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R8
    AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R8
    AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(data_o)); // R8
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end
endmodule

// File: rtl/e2m1_pair_packer.sv
module e2m1_pair_packer
  import e2m1_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  output logic        valid_o,
  output logic [7:0]  byte_o
);
  localparam int LANES  = 2;
  localparam int BYTE_W = LANES * CODE_W;

  logic [FP_W-1:0]   lane_in   [LANES];
  e2m1_t             lane_code [LANES];
  logic [BYTE_W-1:0] packed_d;

  assign lane_in[0] = a_i;
  assign lane_in[1] = b_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    e2m1_rne_cvt u_cvt (
      .val_i  (lane_in[l]),
      .code_o (lane_code[l])
    );
    // lane 0 lands in the high nibble
    assign packed_d[BYTE_W-1-l*CODE_W -: CODE_W] = lane_code[l];
  end

  e2m1_out_stage #(
    .REG_OUT (REG_OUT),
    .W       (BYTE_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (packed_d),
    .valid_o (valid_o),
    .data_o  (byte_o)
  );
endmodule

// File: tb/e2m1_pair_packer_tb.sv
`timescale 1ns/1ps
module e2m1_pair_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_s = 1'b0;
  logic [31:0] a_s = '0, b_s = '0;
  logic        valid_r, valid_c;
  logic [7:0]  byte_r, byte_c;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e2m1_pair_packer #(.REG_OUT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_s), .a_i(a_s), .b_i(b_s),
    .valid_o(valid_r), .byte_o(byte_r));

  e2m1_pair_packer #(.REG_OUT(1'b0)) u_comb (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_s), .a_i(a_s), .b_i(b_s),
    .valid_o(valid_c), .byte_o(byte_c));

  function automatic logic [3:0] ref_code(logic [31:0] f);
    real grid [8] = '{0.0, 0.5, 1.0, 1.5, 2.0, 3.0, 4.0, 6.0};
    int  e = int'(f[30:23]);
    real a, d, bd;
    int  best;
    if (e == 255) return {f[31], 3'd7};
    if (e == 0) a = real'(f[22:0]) * (2.0 ** (-149.0));
    else        a = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (real'(e) - 127.0));
    best = 0; bd = a;
    for (int k = 1; k < 8; k++) begin
      d = (a > grid[k]) ? a - grid[k] : grid[k] - a;
      if (d < bd || (d == bd && (k % 2) == 0)) begin
        best = k; bd = d;
      end
    end
    return {f[31], 3'(best)};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // per-cycle reference for the registered instance
  logic       m_vld = 1'b0;
  logic [7:0] m_byte = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 1'b0; m_byte = '0;
    end else begin
      m_vld = valid_s;
      if (valid_s) m_byte = {ref_code(a_s), ref_code(b_s)};
    end
  end
  always @(negedge clk) if (rst_n && !done) begin
    check("R8 cycle valid", {7'd0, valid_r}, {7'd0, m_vld});
    check("R8 cycle byte", byte_r, m_byte);
  end

  task automatic pair(logic [31:0] a, logic [31:0] b, logic [7:0] exp, string tag);
    @(negedge clk);
    a_s = a; b_s = b; valid_s = 1'b1;
    #1;
    check({tag, " comb"}, byte_c, exp);
    check("R8 comb model", byte_c, {ref_code(a), ref_code(b)});
    @(negedge clk);
    check({tag, " reg"}, byte_r, exp);
    check("R8 valid one cycle later", {7'd0, valid_r}, 8'd1);
    valid_s = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", {7'd0, valid_r}, 8'd0);
    check("R8 reset byte", byte_r, 8'h00);
    rst_n = 1'b1;

    // R1 exact grid points; R7 a high nibble, b low nibble
    pair(32'h3F00_0000, 32'h3F80_0000, 8'h12, "R1 0.5/1.0");
    pair(32'h3FC0_0000, 32'h4000_0000, 8'h34, "R1 1.5/2.0");
    pair(32'h4040_0000, 32'h4080_0000, 8'h56, "R1 3.0/4.0");
    pair(32'h40C0_0000, 32'h0000_0000, 8'h70, "R7 6.0/0.0 order");
    // R2 exponent field 00 only for 0 and 0.5; 1.0 uses 01
    pair(32'h0000_0000, 32'h3F00_0000, 8'h01, "R2 exp00 zero/half");
    // R5 ties to even mantissa
    pair(32'h3E80_0000, 32'h3F40_0000, 8'h02, "R5 0.25/0.75");
    pair(32'h3FA0_0000, 32'h3FE0_0000, 8'h24, "R5 1.25/1.75");
    pair(32'h4020_0000, 32'h4060_0000, 8'h46, "R5 2.5/3.5");
    pair(32'h40A0_0000, 32'hC0A0_0000, 8'h6E, "R5 5.0/-5.0");
    // R4 between midpoints
    pair(32'h3E99_999A, 32'h400C_CCCD, 8'h14, "R4 0.3/2.2");
    pair(32'h402C_CCCD, 32'hBFA6_6666, 8'h5B, "R4 2.7/-1.3");
    pair(32'h3F3D_70A4, 32'h3F42_8F5C, 8'h12, "R4 0.74/0.76");
    // R3 saturation and non-finite
    pair(32'h40E0_0000, 32'h42C8_0000, 8'h77, "R3 7/100");
    pair(32'h7F80_0000, 32'hFF80_0000, 8'h7F, "R3 inf/-inf");
    pair(32'h7FC0_0000, 32'h40A0_0001, 8'h77, "R3 nan/above5");
    // R6 negative zero
    pair(32'h8000_0000, 32'hBE4C_CCCD, 8'h88, "R6 -0/-0.2");
    pair(32'hBDCC_CCCD, 32'h3DCC_CCCD, 8'h80, "R6 -0.1/+0.1");
    // R9 tiny and subnormal
    pair(32'h0000_0001, 32'h3E7F_FFFF, 8'h00, "R9 subnormal/below0.25");

    // R8 hold: valid low, inputs change, byte stays
    @(negedge clk);
    a_s = 32'h40C0_0000; b_s = 32'h40C0_0000;
    @(negedge clk);
    check("R8 hold byte", byte_r, 8'h00);
    check("R8 valid low", {7'd0, valid_r}, 8'd0);

    // R4 random sweep against the nearest-point model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = {1'($urandom), 8'(118 + $urandom_range(0, 14)), 23'($urandom)};
      rb = {1'($urandom), 8'(118 + $urandom_range(0, 14)), 23'($urandom)};
      pair(ra, rb, {ref_code(ra), ref_code(rb)}, "R4 random");
    end

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule